// File: doc/BRIEF.md
# Residue-to-Binary Converter (moduli 8, 7, 5, 3)

This block takes a value held as four residue digits, one for each of the pairwise coprime moduli 8, 7, 5 and 3, and returns the unique binary integer in 0 to 839 that has those residues. 840 is the product of the moduli, so it is the full dynamic range. The conversion is a weighted sum. Each digit is scaled by a constant weight: 105 for the mod-8 digit, 120 for the mod-7 digit, 336 for the mod-5 digit and 280 for the mod-3 digit. The four products are added, and the total is brought into range modulo 840.

The reduction uses no divider. A short chain of compare-and-subtract steps removes 3360, then 1680, then 840, each only where it fits. The design is a two-stage pipeline and accepts one conversion per clock. A valid strobe travels with each result.

Top module: `rns_recon_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is asserted exactly two rising clock edges after a cycle in which `in_valid` was sampled high, and only then.
- R3: `in_res` packs the digits as [10:8] = residue mod 8, [7:5] = residue mod 7, [4:2] = residue mod 5 and [1:0] = residue mod 3. For every legal digit set, `out_data` is the integer x in 0..839 with x mod 8, x mod 7, x mod 5 and x mod 3 equal to those digits.
- R4: All-zero residues convert to 0.
- R5: Residues (1,2,4,0) convert to 9. Their raw weighted sum is 1689.
- R6: Residues (0,1,3,2) convert to 8, and residues (1,1,1,1) convert to 1.
- R7: Whenever `out_valid` is high, `out_data` is below 840.
- R8: `in_res` has no effect while `in_valid` is low. `out_data` keeps the last converted value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_res` as a digit set to convert |
| in_res | input | 11 | Packed residue digits, layout as in R3 |
| out_valid | output | 1 | Marks `out_data` as a fresh result |
| out_data | output | 10 | Reconstructed binary value, 0..839 |

## Verification
The checks assume that each digit sampled with `in_valid` high is below its modulus: at most 7, 6, 4 and 2. Only then is the weighted sum below 3360 and the result unique. A check inside the design flags any illegal digit presented as valid. The stimulus produces valid digit sets by taking the residues of an integer drawn from 0..839. This covers an exhaustive sweep of the range, random values with random idle gaps, and the directed cases. While `in_valid` is low, the bench drives unconstrained 11-bit noise, which may include illegal digits, to show that the noise is ignored.

// File: rtl/rns_recon_pkg.sv
package rns_recon_pkg;

  localparam int NUM_DIG   = 4;
  localparam int DYN_RANGE = 840;

  // index 0 is the most significant field of the input bus
  localparam int MODULI  [NUM_DIG] = '{8, 7, 5, 3};
  localparam int WEIGHTS [NUM_DIG] = '{105, 120, 336, 280};

  function automatic int dig_width(input int idx);
    return $clog2(MODULI[idx]);
  endfunction

  function automatic int dig_lsb(input int idx);
    int pos;
    pos = 0;
    for (int j = idx + 1; j < NUM_DIG; j++) pos += dig_width(j);
    return pos;
  endfunction

  function automatic int bus_width();
    int tot;
    tot = 0;
    for (int j = 0; j < NUM_DIG; j++) tot += dig_width(j);
    return tot;
  endfunction

  // largest sum reachable from any bit pattern on the bus
  function automatic int max_raw_sum();
    int tot;
    tot = 0;
    for (int j = 0; j < NUM_DIG; j++) tot += ((1 << dig_width(j)) - 1) * WEIGHTS[j];
    return tot;
  endfunction

  // largest sum reachable from legal digits
  function automatic int max_legal_sum();
    int tot;
    tot = 0;
    for (int j = 0; j < NUM_DIG; j++) tot += (MODULI[j] - 1) * WEIGHTS[j];
    return tot;
  endfunction

  localparam int IN_W    = bus_width();
  localparam int OUT_W   = $clog2(DYN_RANGE);
  localparam int SUM_W   = $clog2(max_raw_sum() + 1);
  localparam int RED_STG = $clog2(max_raw_sum() / DYN_RANGE + 1);

endpackage

// File: rtl/rns_digit_weight.sv
module rns_digit_weight #(
  parameter int DW     = 3,
  parameter int WEIGHT = 105,
  parameter int PW     = 13
) (
  input  logic [DW-1:0] digit,
  output logic [PW-1:0] product
);

  always_comb begin
    product = PW'(digit) * PW'(WEIGHT);
  end

endmodule

// File: rtl/rns_range_reduce.sv
module rns_range_reduce #(
  parameter int SUM_W  = 13,
  parameter int MODV   = 840,
  parameter int STAGES = 3
) (
  input  logic [SUM_W-1:0] sum_in,
  output logic [SUM_W-1:0] rem_out
);

  logic [SUM_W-1:0] chain [STAGES+1];

  assign chain[STAGES] = sum_in;

  // step k strips MODV * 2^k when it fits, largest step first
  for (genvar k = STAGES - 1; k >= 0; k--) begin : g_step
    localparam logic [SUM_W-1:0] SUBV = SUM_W'(MODV << k);
    always_comb begin
      if (chain[k+1] >= SUBV) chain[k] = chain[k+1] - SUBV;
      else                    chain[k] = chain[k+1];
    end
  end

  assign rem_out = chain[0];

endmodule

// File: rtl/rns_recon_top.sv
module rns_recon_top
  import rns_recon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_res,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic [SUM_W-1:0] prod [NUM_DIG];
  logic [SUM_W-1:0] wsum;
  logic [SUM_W-1:0] s1_sum;
  logic             s1_vld;
  logic [SUM_W-1:0] rem;

  // per-digit scaling
  for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
    localparam int DW  = dig_width(i);
    localparam int LSB = dig_lsb(i);
    logic [DW-1:0] dig;
    assign dig = in_res[LSB +: DW];

    rns_digit_weight #(
      .DW     (DW),
      .WEIGHT (WEIGHTS[i]),
      .PW     (SUM_W)
    ) u_wt (
      .digit   (dig),
      .product (prod[i])
    );

    AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst) in_valid |-> (int'(dig) < MODULI[i])) else $error("illegal residue digit"); // R3
  end

  always_comb begin
    wsum = '0;
    for (int i = 0; i < NUM_DIG; i++) wsum = wsum + prod[i];
  end

  // stage 1: weighted sum
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_sum <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) s1_sum <= wsum;
    end
  end

  rns_range_reduce #(
    .SUM_W  (SUM_W),
    .MODV   (DYN_RANGE),
    .STAGES (RED_STG)
  ) u_red (
    .sum_in  (s1_sum),
    .rem_out (rem)
  );

  // stage 2: reduced result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) out_data <= rem[OUT_W-1:0];
    end
  end

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst) s1_vld |-> (int'(s1_sum) <= max_legal_sum())) else $error("weighted sum out of legal range"); // R3
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst) s1_vld |-> (int'(rem) < DYN_RANGE)) else $error("reduction left remainder too large"); // R7
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (int'(out_data) < DYN_RANGE)) else $error("output above range"); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst) s1_vld |=> out_valid) else $error("valid lost in pipeline"); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_data)) else $error("output moved without valid"); // R8
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst) (s1_vld && s1_sum == '0) |=> (out_data == '0)) else $error("zero sum not mapped to zero"); // R4

endmodule

// File: tb/rns_recon_top_tb_top.sv
`timescale 1ns/1ps
module rns_recon_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [10:0] in_res;
  logic        out_valid;
  logic [9:0]  out_data;

  int checks = 0;
  int errors = 0;

  // history of what was driven one and two negedges ago
  logic        hv0 = 1'b0, hv1 = 1'b0;
  logic [10:0] hr0 = '0, hr1 = '0;
  string       ht0 = "R3", ht1 = "R3";
  int          last_exp = 0;

  always #10 clk = ~clk;

  rns_recon_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_res    (in_res),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [10:0] encode(input int x);
    return {3'(x % 8), 3'(x % 7), 3'(x % 5), 2'(x % 3)};
  endfunction

  // search for the integer whose residues match; no weights involved
  function automatic int ref_value(input logic [10:0] r);
    for (int x = 0; x < 840; x++) begin
      if (encode(x) == r) return x;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called right after a negedge: check outputs, then drive the next beat
  task automatic beat(input logic v, input logic [10:0] r, input string tag);
    int exp;
    chk(out_valid === hv1, "R2", int'(out_valid), int'(hv1));
    if (hv1) begin
      exp = ref_value(hr1);
      chk(int'(out_data) == exp, ht1, int'(out_data), exp);
      chk(out_data < 10'd840, "R7", int'(out_data), 839);
      last_exp = exp;
    end else begin
      chk(int'(out_data) == last_exp, "R8", int'(out_data), last_exp);
    end
    hv1 = hv0; hr1 = hr0; ht1 = ht0;
    hv0 = v;   hr0 = r;   ht0 = tag;
    in_valid = v;
    in_res   = r;
    @(negedge clk);
  endtask

  task automatic idle();
    beat(1'b0, 11'($urandom), "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    rst = 1'b1;
    in_valid = 1'b0;
    in_res = 11'h7ff;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(out_data === 10'd0, "R1", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(out_data === 10'd0, "R1", int'(out_data), 0);

    // directed corner cases
    beat(1'b1, 11'b000_000_000_00, "R4");
    beat(1'b1, {3'd1, 3'd2, 3'd4, 2'd0}, "R5");
    beat(1'b1, {3'd0, 3'd1, 3'd3, 2'd2}, "R6");
    beat(1'b1, {3'd1, 3'd1, 3'd1, 2'd1}, "R6");
    beat(1'b1, encode(839), "R3");
    idle();
    idle();
    beat(1'b1, encode(1), "R3");
    idle();
    idle();
    idle();
    beat(1'b1, 11'b000_000_000_00, "R4");

    // exhaustive sweep, back to back
    for (int x = 0; x < 840; x++) beat(1'b1, encode(x), "R3");

    // random values with random gaps and noise on the idle bus
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) != 0) beat(1'b1, encode(int'($urandom_range(0, 839))), "R3");
      else idle();
    end

    // drain
    idle();
    idle();
    idle();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule